// File: doc/BRIEF.md
# Auto-Reload Down Timer with Prescaler

This block is an 8-bit down-counting timer with a reload register. A prescaler divides the clock and feeds the timer. It is meant as a timer peripheral in a small controller. The host has four operations: a strobe that writes both the live count and the reload value, a strobe that writes only the reload value, a 4-bit control write, and a read of the live count, which appears on its own output port.

The prescaler sends a one-clock count pulse every 4 or every 16 clocks. While counting is enabled, each pulse lowers the count by one. A pulse that arrives when the count is already zero is an underflow. An underflow reloads the count from the reload register, sets a sticky request flag and toggles a square-wave output. A value n therefore gives one underflow every n+1 count pulses. Counting can start as soon as the run bit is set. It can also wait for a rising edge on an asynchronous start pin, which first passes through a synchroniser.

The control field has four bits. Bit 3 enables the prescaler. Bit 2 selects its ratio. Bit 1 runs the timer. Bit 0 arms the start-on-edge mode.

Top module: `artmr_top`

## Requirements
- R1: With control bit 3 set, the prescaler gives one count pulse every 4 clocks if control bit 2 is 0, and every 16 clocks if it is 1. With bit 3 clear, the prescaler is held in reset and gives no pulses.
- R2: While counting is enabled, each count pulse lowers the count by one. With counting disabled, or with no pulse, the count holds its value.
- R3: A count pulse that arrives while the count is 0 is an underflow. It loads the reload value into the count, so a value n gives one underflow every n+1 pulses (n = 0 to 255).
- R4: The load-both strobe writes its data into the count and the reload register on the next clock edge. It takes priority over counting, and no underflow happens in that cycle.
- R5: The reload-only strobe changes the reload register but leaves the live count alone. The new value takes effect from the next underflow.
- R6: With control bit 1 set and control bit 0 clear, counting is enabled at once.
- R7: With control bits 1 and 0 both set, counting stays disabled until the first rising edge of the start pin after a two-flop synchroniser. Later edges have no effect. Clearing either bit disarms the mode again.
- R8: An underflow sets the request flag. The flag stays set until the clear strobe. If a clear and an underflow happen in the same cycle, the flag stays set.
- R9: The square-wave output toggles once on every underflow and holds its level otherwise.
- R10: After reset, the control field, count, reload value, flag and square-wave output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler's source |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_both | input | 1 | Strobe: write wr_data into count and reload |
| ld_reload | input | 1 | Strobe: write wr_data into reload only |
| wr_data | input | 8 | Data for the load strobes |
| ctl_we | input | 1 | Strobe: write ctl_wdata into the control field |
| ctl_wdata | input | 4 | Control: [3] prescaler enable, [2] ratio, [1] run, [0] start-on-edge |
| flag_clr | input | 1 | Strobe: clear the request flag |
| start_pin | input | 1 | Asynchronous external start input |
| count_o | output | 8 | Live count value |
| irq_flag | output | 1 | Sticky underflow request flag |
| sq_out | output | 1 | Output that toggles on each underflow |

## Verification
The bound checker checks these rules on every cycle:
- the prescaler gives no pulse while it is disabled;
- the count holds or lowers by one according to the internal count enable;
- an underflow loads the reload value, sets the flag and toggles the square wave;
- a load-both write lands on the next edge;
- a clear without an underflow drops the flag.

Only the bench scenarios can show the following:
- the end-to-end periods of (n+1) times 4 or 16 clocks;
- a reload-only write taking effect one underflow later;
- the start-on-edge mode ignoring the pin until its synchronised edge, and ignoring later edges.

A cycle-accurate reference model in the bench compares the count, flag and square wave on every cycle during both the directed and the random stimulus.

// File: rtl/artmr_pkg.sv
package artmr_pkg;

  typedef struct packed {
    logic pre_en;
    logic pre_sel;
    logic run;
    logic edge_arm;
  } ctl_t;

  function automatic logic [3:0] psc_last(input logic sel, input int lo, input int hi);
    int d;
    d = sel ? hi : lo;
    return 4'(d - 1);
  endfunction

  function automatic logic [7:0] next_down(input logic [7:0] v);
    return v - 8'd1;
  endfunction

endpackage

// File: rtl/artmr_prescaler.sv
module artmr_prescaler #(
  parameter int PSC_W  = 4,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  output logic tick
);
  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] last;

  assign last = PSC_W'(sel ? DIV_HI - 1 : DIV_LO - 1);
  assign tick = en && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pcnt <= '0;
    else if (pcnt == last) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/artmr_trigsync.sv
module artmr_trigsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic armed,
  output logic started
);
  logic [STAGES:0] sh;
  logic rise;

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      started <= 1'b0;
    end else begin
      sh <= {sh[STAGES-1:0], pin};
      if (!armed) started <= 1'b0;
      else if (rise) started <= 1'b1;
    end
  end
endmodule

// File: rtl/artmr_counter.sv
module artmr_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen,
  input  logic              ld_both,
  input  logic              ld_reload,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rel,
  output logic              uf,
  output logic              flag,
  output logic              sq
);
  assign uf = cen && (cnt == '0) && !ld_both;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      rel  <= '0;
      flag <= 1'b0;
      sq   <= 1'b0;
    end else begin
      if (ld_both) cnt <= wr_data;
      else if (uf) cnt <= rel;
      else if (cen) cnt <= cnt - 1'b1;
      if (ld_both || ld_reload) rel <= wr_data;
      if (uf) flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (uf) sq <= ~sq;
    end
  end
endmodule

// File: rtl/artmr_top.sv
module artmr_top #(
  parameter int DATA_W = 8,
  parameter int PSC_W  = 4,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_both,
  input  logic              ld_reload,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic              flag_clr,
  input  logic              start_pin,
  output logic [DATA_W-1:0] count_o,
  output logic              irq_flag,
  output logic              sq_out
);
  import artmr_pkg::*;

  ctl_t ctl_q;
  logic tick_w, started_w, active_w, cen_w, uf_w;
  logic [DATA_W-1:0] rel_w;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  artmr_prescaler #(.PSC_W(PSC_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(ctl_q.pre_en), .sel(ctl_q.pre_sel), .tick(tick_w)
  );

  artmr_trigsync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(start_pin),
    .armed(ctl_q.run && ctl_q.edge_arm), .started(started_w)
  );

  assign active_w = ctl_q.run && (!ctl_q.edge_arm || started_w);
  assign cen_w    = active_w && tick_w;

  artmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cen(cen_w), .ld_both(ld_both), .ld_reload(ld_reload),
    .wr_data(wr_data), .flag_clr(flag_clr), .cnt(count_o), .rel(rel_w),
    .uf(uf_w), .flag(irq_flag), .sq(sq_out)
  );
endmodule

// File: rtl/artmr_chk.sv
module artmr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uf,
  input logic              cen,
  input logic              tick,
  input logic              pre_en,
  input logic              ld_both,
  input logic              flag_clr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] rel,
  input logic              flag,
  input logic              sq
);
  // R1
  psc_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !pre_en |-> !tick);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!cen && !ld_both) |=> $stable(cnt));
  // R2
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && !ld_both && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n) uf |=> cnt == $past(rel));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_both |=> cnt == $past(wr_data));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n) uf |=> flag);
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !uf) |=> !flag);
  // R9
  sq_flip_chk: assert property (@(posedge clk) disable iff (!rst_n) uf |=> sq != $past(sq));
  // R9
  sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !uf |=> $stable(sq));
endmodule

bind artmr_top artmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uf(uf_w), .cen(cen_w), .tick(tick_w), .pre_en(ctl_q.pre_en),
  .ld_both(ld_both), .flag_clr(flag_clr), .wr_data(wr_data), .cnt(count_o), .rel(rel_w),
  .flag(irq_flag), .sq(sq_out)
);

// File: tb/artmr_top_tb.sv
module artmr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ld_both = 0, ld_reload = 0, ctl_we = 0, flag_clr = 0, start_pin = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] ctl_wdata = 0;
  logic [7:0] count_o;
  logic irq_flag, sq_out;

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  artmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .ld_both(ld_both), .ld_reload(ld_reload), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .flag_clr(flag_clr), .start_pin(start_pin),
    .count_o(count_o), .irq_flag(irq_flag), .sq_out(sq_out)
  );

  // Reference model derived from the requirements
  function automatic int period_of(input logic sel);
    return sel ? 16 : 4;
  endfunction

  logic [3:0] m_ctl;
  int m_phase;
  logic [2:0] m_pipe;
  logic m_hit;
  logic [7:0] m_cnt, m_rel;
  logic m_flag, m_sq;
  logic m_pulse, m_go, m_und;

  always_comb begin
    m_pulse = m_ctl[3] && (m_phase == period_of(m_ctl[2]) - 1);
    m_go    = m_ctl[1] && (m_ctl[0] ? m_hit : 1'b1);
    m_und   = m_go && m_pulse && !ld_both && (m_cnt == 8'd0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl <= 0; m_phase <= 0; m_pipe <= 0; m_hit <= 0;
      m_cnt <= 0; m_rel <= 0; m_flag <= 0; m_sq <= 0;
    end else begin
      m_ctl   <= ctl_we ? ctl_wdata : m_ctl;
      m_phase <= (!m_ctl[3] || m_pulse) ? 0 : (m_phase + 1) % 16;
      m_pipe  <= {m_pipe[1:0], start_pin};
      if (m_ctl[1] && m_ctl[0]) begin
        if (m_pipe[1] && !m_pipe[2]) m_hit <= 1;
      end else m_hit <= 0;
      if (ld_both) m_cnt <= wr_data;
      else if (m_und) m_cnt <= m_rel;
      else if (m_go && m_pulse) m_cnt <= m_cnt - 8'd1;
      if (ld_both || ld_reload) m_rel <= wr_data;
      m_flag <= m_und | (m_flag & ~flag_clr);
      m_sq   <= m_sq ^ m_und;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc_n);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    if (rst_n) begin
      check({tag, " count"}, count_o, m_cnt);
      check({tag, " flag"}, irq_flag, m_flag);
      check({tag, " sq"}, sq_out, m_sq);
    end
  endtask

  task automatic idle();
    ld_both = 0; ld_reload = 0; ctl_we = 0; flag_clr = 0;
  endtask

  task automatic gap(output int g);
    logic t0;
    int k;
    t0 = sq_out; k = 0;
    while (sq_out == t0 && k < 2000) begin cyc(); k++; end
    t0 = sq_out; g = 0;
    while (sq_out == t0 && g < 2000) begin cyc(); g++; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int g;
    logic [7:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset values
    check("R10 count", count_o, 0); check("R10 flag", irq_flag, 0); check("R10 sq", sq_out, 0);

    // R4: load-both lands next edge; R2: held while stopped
    tag = "R4"; wr_data = 8'd5; ld_both = 1; cyc(); idle();
    check("R4 count", count_o, 5);
    tag = "R2"; repeat (10) cyc();
    check("R2 hold", count_o, 5);

    // R6 / R3: run at /4, period (5+1)*4
    tag = "R6"; ctl_wdata = 4'b1010; ctl_we = 1; cyc(); idle();
    tag = "R3"; gap(g);
    check("R3 period", g, 24);
    check("R8 flag set", irq_flag, 1);

    // R8: clear strobe
    tag = "R8"; flag_clr = 1; cyc(); idle(); cyc();

    // R5: reload-only write, new value applies after next underflow
    tag = "R5"; snap = count_o; wr_data = 8'd1; ld_reload = 1; cyc(); idle();
    check("R5 count untouched", int'(count_o == snap || count_o == snap - 8'd1 || count_o == 8'd5), 1);
    gap(g);
    check("R5 new period", g, 8);

    // R1: /16 ratio with value 0
    tag = "R1"; ctl_wdata = 4'b0000; ctl_we = 1; cyc(); idle();
    wr_data = 8'd0; ld_both = 1; cyc(); idle();
    ctl_wdata = 4'b1110; ctl_we = 1; cyc(); idle();
    gap(g);
    check("R1 period /16", g, 16);
    ctl_wdata = 4'b0010; ctl_we = 1; cyc(); idle();
    snap = count_o; repeat (40) cyc();
    check("R1 no pulses when disabled", count_o, snap);

    // R7: start-on-edge
    tag = "R7"; ctl_wdata = 4'b0000; ctl_we = 1; cyc(); idle();
    wr_data = 8'd3; ld_both = 1; cyc(); idle();
    ctl_wdata = 4'b1011; ctl_we = 1; cyc(); idle();
    repeat (30) cyc();
    check("R7 waits for edge", count_o, 3);
    start_pin = 1; repeat (40) cyc();
    check("R7 started after edge", int'(count_o != 8'd3 || sq_out != 0), 1);
    start_pin = 0; repeat (5) cyc(); start_pin = 1; repeat (20) cyc();

    // R9 / R2: constrained random against the model
    tag = "R9";
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [3:0] nc;
      r = $urandom % 100;
      idle();
      wr_data = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8);
      if (r < 2) ld_both = 1;
      else if (r < 5) ld_reload = 1;
      else if (r < 7) begin
        nc = 4'($urandom);
        if (m_ctl[3] && nc[3]) nc[2] = m_ctl[2];
        ctl_wdata = nc; ctl_we = 1;
      end else if (r < 10) flag_clr = 1;
      if ($urandom % 100 < 3) start_pin = ~start_pin;
      if (i == 3000) tag = "R2";
      cyc();
    end
    idle();
    cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule